// File: doc/BRIEF.md
# Multiphase Sampling Phase Controller

The controller picks one of sixteen evenly spaced phases of the sampling clock as the strobe for the converter. One phase step is one sixteenth of a clock period. The chosen phase is the modulo-16 sum of three corrections:
- an absolute starting phase, loaded once timing acquisition has settled;
- a slow drift term built up from the normalized sampling-clock offset;
- single-step nudges from pilot tracking.

Acquisition can also ask for a half-period jump of eight phases between its two training-symbol captures.

A phase that moves past a whole clock period gives a one-cycle slip pulse, so the datapath that follows can add or drop a sample. The drift term comes from a 28-bit accumulator. On each sample strobe it adds sixteen times the stored offset word, which has 24 fractional bits. A change in its integer part moves the phase by one step. Every correction that arrives in the same cycle is added before the wrap is applied, so no correction is lost. A packet-start clear returns the phase and the accumulator to zero.

Top module: `mphase_sel_ctrl`

## Requirements
- R1: After reset, `phase_sel` is 0 and neither slip output is asserted.
- R2: A cycle with `pkt_start` high sets `phase_sel` to 0 and clears the drift accumulator on the following edge, whatever else is requested in that cycle. The stored offset word is kept.
- R3: When `acq_valid` is high, `acq_phase` replaces the current phase as the base of that cycle's sum.
- R4: `half_shift` adds 8 phases to the sum.
- R5: When `trk_valid` is high, the sum gets -1 if `trk_late` is 1 (drift measured late) and +1 if `trk_late` is 0.
- R6: `sco_valid` stores the signed 20-bit `sco_delta` (24 fractional bits). On each `sample_stb` the 28-bit accumulator adds the stored word times 16. A change of its top 4 bits (+1 or -1) is added to the sum. With `sco_valid` and `sample_stb` in the same cycle, the accumulator uses the previously stored word.
- R7: All corrections requested in one cycle are added into a single sum before the wrap.
- R8: `phase_sel` is the sum modulo 16. A sum of 16 or more raises `slip_late` for exactly one cycle.
- R9: A negative sum raises `slip_early` for exactly one cycle.
- R10: All outputs are registered and change on the edge that samples the request. In a cycle with no request, `phase_sel` holds and both slip outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_start | input | 1 | Packet-start clear of phase and accumulator |
| acq_valid | input | 1 | Load strobe for the acquired initial phase |
| acq_phase | input | 4 | Initial phase from acquisition |
| half_shift | input | 1 | Request for an 8-phase (half-period) jump |
| trk_valid | input | 1 | Pilot-tracking decision strobe |
| trk_late | input | 1 | 1: drift measured late, step -1; 0: step +1 |
| sco_valid | input | 1 | Load strobe for the offset word |
| sco_delta | input | 20 | Signed normalized clock offset, 24 fractional bits |
| sample_stb | input | 1 | One pulse per converter sample |
| phase_sel | output | 4 | Selected clock phase |
| slip_late | output | 1 | One-cycle pulse when the phase wraps upward |
| slip_early | output | 1 | One-cycle pulse when the phase wraps downward |

## Verification
A corrupted phase register shows on `phase_sel` one edge after the request that should have set it, and it stays visible until the next clear or acquisition load. A wrong accumulator value is hidden in the fraction. It shows only as a drift step on the wrong sample strobe, which can be many strobes later, so the bench runs long strobe trains with known offset words and compares every cycle. Lost or double-counted corrections in a cycle that carries several of them show at once as a wrong phase and a missing or spurious slip pulse. Clears that arrive together with other requests show whether the clear has priority.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic {
    TRK_ADVANCE = 1'b0,
    TRK_RETARD  = 1'b1
  } trk_dir_e;

  typedef struct packed {
    logic late;
    logic early;
  } slip_t;
endpackage

// File: rtl/mps_rst_sync.sv
module mps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mps_drift_acc.sv
module mps_drift_acc #(
  parameter int PH_W    = 4,
  parameter int FRAC_W  = 24,
  parameter int DELTA_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               stb_i,
  input  logic               ld_i,
  input  logic [DELTA_W-1:0] delta_i,
  output logic [1:0]         step_o
);
  localparam int ACC_W = FRAC_W + PH_W;
  localparam int EXT_W = ACC_W - DELTA_W;

  logic [DELTA_W-1:0] delta_q, delta_d;
  logic [ACC_W-1:0]   acc_q, acc_d, inc;
  logic [PH_W-1:0]    int_diff;
  logic               acc_en, delta_en;

  // offset word times the phase count, sign extended
  assign inc = {{EXT_W{delta_q[DELTA_W-1]}}, delta_q} << PH_W;

  always_comb begin
    delta_en = ld_i;
    delta_d  = delta_i;
    acc_en   = clr_i | stb_i;
    acc_d    = acc_q;
    if (clr_i)      acc_d = '0;
    else if (stb_i) acc_d = acc_q + inc;
  end

  assign int_diff = acc_d[ACC_W-1:FRAC_W] - acc_q[ACC_W-1:FRAC_W];
  assign step_o   = (stb_i && !clr_i) ? int_diff[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      delta_q <= '0;
    end else begin
      if (acc_en)   acc_q   <= acc_d;
      if (delta_en) delta_q <= delta_d;
    end
  end

  // R6: the increment stays below one phase, so the integer part moves by at most one
  p_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !clr_i) |-> (int_diff == '0 || int_diff == PH_W'(1) || int_diff == '1));

  // R6: the accumulator only moves on a strobe or a clear
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/mps_phase_merge.sv
module mps_phase_merge #(
  parameter int PH_W = 4
) (
  input  logic [PH_W-1:0] base_i,
  input  logic            half_i,
  input  logic            trk_i,
  input  logic            trk_ret_i,
  input  logic [1:0]      drift_i,
  output logic [PH_W-1:0] phase_o,
  output logic            late_o,
  output logic            early_o
);
  import mps_pkg::*;

  localparam int SUM_W  = PH_W + 2;
  localparam int NUM_PH = 1 << PH_W;
  localparam int HALF   = NUM_PH / 2;

  logic signed [SUM_W-1:0] t_base, t_half, t_trk, t_drift, sum;

  always_comb begin
    t_base  = $signed({2'b00, base_i});
    t_half  = half_i ? SUM_W'(HALF) : '0;
    t_trk   = '0;
    if (trk_i) t_trk = (trk_dir_e'(trk_ret_i) == TRK_RETARD) ? '1 : SUM_W'(1);
    t_drift = $signed({{(SUM_W-2){drift_i[1]}}, drift_i});
    sum     = t_base + t_half + t_trk + t_drift;
    phase_o = sum[PH_W-1:0];
    early_o = sum[SUM_W-1];
    late_o  = !sum[SUM_W-1] && (sum[SUM_W-2:PH_W] != '0);
  end
endmodule

// File: rtl/mphase_sel_ctrl.sv
module mphase_sel_ctrl #(
  parameter int PH_W    = 4,
  parameter int FRAC_W  = 24,
  parameter int DELTA_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_start,
  input  logic               acq_valid,
  input  logic [PH_W-1:0]    acq_phase,
  input  logic               half_shift,
  input  logic               trk_valid,
  input  logic               trk_late,
  input  logic               sco_valid,
  input  logic [DELTA_W-1:0] sco_delta,
  input  logic               sample_stb,
  output logic [PH_W-1:0]    phase_sel,
  output logic               slip_late,
  output logic               slip_early
);
  import mps_pkg::*;

  localparam int HALF = (1 << PH_W) / 2;

  logic            rst_s_n;
  logic [1:0]      drift_step;
  logic [PH_W-1:0] base, phase_q, phase_d, m_phase;
  logic            m_late, m_early, upd_en, any_req;
  slip_t           slip_q, slip_d;

  mps_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  mps_drift_acc #(.PH_W(PH_W), .FRAC_W(FRAC_W), .DELTA_W(DELTA_W)) u_drift (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr_i   (pkt_start),
    .stb_i   (sample_stb),
    .ld_i    (sco_valid),
    .delta_i (sco_delta),
    .step_o  (drift_step)
  );

  assign base = acq_valid ? acq_phase : phase_q;

  mps_phase_merge #(.PH_W(PH_W)) u_merge (
    .base_i    (base),
    .half_i    (half_shift),
    .trk_i     (trk_valid),
    .trk_ret_i (trk_late),
    .drift_i   (drift_step),
    .phase_o   (m_phase),
    .late_o    (m_late),
    .early_o   (m_early)
  );

  always_comb begin
    any_req = pkt_start | acq_valid | half_shift | trk_valid | sample_stb;
    upd_en  = any_req | slip_q.late | slip_q.early;
    if (pkt_start) begin
      phase_d = '0;
      slip_d  = '{late: 1'b0, early: 1'b0};
    end else begin
      phase_d = m_phase;
      slip_d  = '{late: m_late, early: m_early};
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase_q <= '0;
      slip_q  <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      slip_q  <= slip_d;
    end
  end

  assign phase_sel  = phase_q;
  assign slip_late  = slip_q.late;
  assign slip_early = slip_q.early;

  // R2: a clear wins over every other request
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    pkt_start |=> (phase_sel == '0 && !slip_late && !slip_early));

  // R8, R9: a single sum cannot wrap both ways
  p_slip_excl_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(slip_late && slip_early));

  // R10: with no request the phase holds and no slip is flagged
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !any_req |=> ($stable(phase_sel) && !slip_late && !slip_early));

  // R4: a lone half-period request moves the phase by eight
  p_half_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (half_shift && !pkt_start && !acq_valid && !trk_valid && !sample_stb) |=>
      (phase_sel == $past(phase_sel) + PH_W'(HALF)));

  // R8: a lone half-period request slips exactly when the old phase was in the upper half
  p_half_slip_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (half_shift && !pkt_start && !acq_valid && !trk_valid && !sample_stb) |=>
      (slip_late == $past(phase_sel[PH_W-1])));
endmodule

// File: tb/mphase_sel_ctrl_bench.sv
module mphase_sel_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_start, acq_valid, half_shift, trk_valid, trk_late, sco_valid, sample_stb;
  logic [3:0]  acq_phase;
  logic [19:0] sco_delta;
  logic [3:0]  phase_sel;
  logic        slip_late, slip_early;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [27:0] m_acc;
  logic [19:0] m_delta;
  int          m_phase;
  bit          m_late, m_early;

  always #(CLK_PERIOD/2) clk = ~clk;

  mphase_sel_ctrl u_mphase_sel_ctrl (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .acq_valid(acq_valid),
    .acq_phase(acq_phase), .half_shift(half_shift), .trk_valid(trk_valid),
    .trk_late(trk_late), .sco_valid(sco_valid), .sco_delta(sco_delta),
    .sample_stb(sample_stb), .phase_sel(phase_sel), .slip_late(slip_late),
    .slip_early(slip_early)
  );

  function automatic int drift_of(logic [27:0] acc, logic [19:0] d, output logic [27:0] nacc);
    logic [3:0] di;
    nacc = acc + ({{8{d[19]}}, d} << 4);
    di   = nacc[27:24] - acc[27:24];
    return (di == 4'hF) ? -1 : int'(di);
  endfunction

  task automatic check(string tag);
    checks++;
    if (phase_sel !== 4'(m_phase) || slip_late !== m_late || slip_early !== m_early) begin
      errors++;
      $display("FAIL %s: got phase=%0d late=%0b early=%0b, expected phase=%0d late=%0b early=%0b",
               tag, phase_sel, slip_late, slip_early, m_phase, m_late, m_early);
    end
  endtask

  task automatic cyc(bit pk, bit aq, int aph, bit hf, bit tv, bit tl,
                     bit sv, logic [19:0] sd, bit sb, string tag);
    int sum;
    int ds;
    logic [27:0] nacc;
    @(negedge clk);
    pkt_start = pk; acq_valid = aq; acq_phase = 4'(aph); half_shift = hf;
    trk_valid = tv; trk_late = tl; sco_valid = sv; sco_delta = sd; sample_stb = sb;
    if (pk) begin
      m_acc = '0; m_phase = 0; m_late = 0; m_early = 0;
    end else begin
      ds = 0;
      if (sb) begin
        ds = drift_of(m_acc, m_delta, nacc);
        m_acc = nacc;
      end
      sum = (aq ? aph : m_phase) + (hf ? 8 : 0) + (tv ? (tl ? -1 : 1) : 0) + ds;
      m_late  = (sum > 15);
      m_early = (sum < 0);
      m_phase = (sum + 16) % 16;
    end
    if (sv) m_delta = sd;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 0;
    pkt_start = 0; acq_valid = 0; acq_phase = 0; half_shift = 0;
    trk_valid = 0; trk_late = 0; sco_valid = 0; sco_delta = 0; sample_stb = 0;
    m_acc = '0; m_delta = '0; m_phase = 0; m_late = 0; m_early = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 reset state");

    cyc(0,1,12,0,0,0,0,0,0, "R3 load initial phase");
    cyc(0,0,0,1,0,0,0,0,0,  "R4 R8 half shift wraps up");
    cyc(0,0,0,0,0,0,0,0,0,  "R10 idle hold, slip ends");
    cyc(0,1,0,0,1,1,0,0,0,  "R5 R9 load zero and retard");
    cyc(0,0,0,0,1,0,0,0,0,  "R5 R8 advance wraps up");
    cyc(0,0,0,0,1,0,0,0,0,  "R5 advance");

    cyc(0,0,0,0,0,0,1,20'h40000,1, "R6 strobe uses old word");
    for (int i = 0; i < 8; i++) cyc(0,0,0,0,0,0,0,0,1, "R6 positive drift train");
    cyc(0,0,0,0,0,0,1,20'hC0000,0, "R6 load negative word");
    for (int i = 0; i < 12; i++) cyc(0,0,0,0,0,0,0,0,1, "R6 negative drift train");

    cyc(0,1,14,1,1,0,0,0,1, "R7 all corrections at once");
    cyc(0,1,0,0,1,1,0,0,1,  "R7 R9 load zero with retard and drift");
    cyc(1,1,9,1,1,0,0,0,1,  "R2 clear beats other requests");
    cyc(0,0,0,0,0,0,0,0,1,  "R2 accumulator cleared");
    cyc(0,0,0,0,0,0,0,0,0,  "R10 hold");

    for (int i = 0; i < 3000; i++) begin
      bit pk, aq, hf, tv, tl, sv, sb;
      int aph;
      logic [19:0] sd;
      pk  = ($urandom % 64) == 0;
      aq  = ($urandom % 16) == 0;
      aph = int'($urandom % 16);
      hf  = ($urandom % 16) == 0;
      tv  = ($urandom % 8) == 0;
      tl  = $urandom % 2;
      sv  = ($urandom % 24) == 0;
      sd  = 20'($urandom);
      sb  = $urandom % 2;
      cyc(pk, aq, aph, hf, tv, tl, sv, sd, sb, "R7 R8 R9 random mix");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule